// File: doc/BRIEF.md
# Prescaled Auto-Reload Down Timer

A down-counting timer that is configured and read over a small register bus. Software writes a reload value and a control word. Setting the start bit loads the counter from the reload value. From then on, the counter steps down once per prescaler period. That period is a power of two between 2 and 256 clocks. The counter moves only while three things are all true: the start bit is set, the count enable is set and the functional clock enable input is high. Whenever any of them drops, the counter and the prescaler freeze.

When the count expires, a one-shot timer parks at zero and clears its own start bit. An auto-reload timer instead reloads the programmed value and keeps running. On every expiry, if the interrupt enable is set, the block raises a single-cycle interrupt pulse. The count register always reads the live value.

Top module: `tmr_top`

## Requirements
- R1: After reset, the control register reads 0, the count register reads 0, the prescaler is cleared and `irq_o` is low.
- R2: Register map, selected by `reg_addr_i`:
  - Address 0 is control, with bit 6 interrupt enable, bit 5 count enable, bits 4:2 prescale exponent p, bit 1 auto-reload and bit 0 start.
  - Address 1 is the reload value.
  - Address 2 is the live count, which is read-only.
  - Address 3 reads 0.
  - Reads are combinational. Writes take effect at the clock edge when `reg_we_i` is high.
- R3: A control write that sets start while start is clear does three things: it loads the counter with the reload value held before that edge, it clears the prescaler, and it sets start.
- R4: While running, the prescaler counts clocks. A tick occurs when the prescaler's low p+1 bits are all ones; the prescaler then returns to 0. The counter therefore decrements once every 2^(p+1) clocks.
- R5: When start, count enable or `fclk_en_i` is low, the counter and the prescaler hold their values.
- R6: Expiry is a tick with the count at 1 or at 0, so a reload value of 0 expires on the first tick. On expiry without auto-reload, the count becomes 0 and start clears.
- R7: On expiry with auto-reload, the counter reloads the reload value and counting continues.
- R8: Each expiry with interrupt enable set drives `irq_o` high for exactly the one cycle after the expiry edge. With interrupt enable clear, `irq_o` stays low.
- R9: A control write in the same cycle as an expiry wins: the control register takes the written value, including start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fclk_en_i | input | 1 | Functional clock active |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register select |
| reg_wdata_i | input | DATA_W | Write data |
| reg_rdata_o | output | DATA_W | Read data for the selected register |
| irq_o | output | 1 | Expiry interrupt pulse |

## Verification
Directed sequences cover four cases:
- A one-shot countdown at the fastest prescale, which separates the correct period from an off-by-one tick and shows that start clears at expiry.
- An auto-reload run with the interrupt disabled, which shows that reload happens without any pulse.
- Gating of the functional clock, which shows that the count holds.
- A control write colliding with expiry, which confirms that the write wins.

A long random phase then mixes writes of reload values (including 0 and 1), prescale exponents, toggling enables and functional-clock gaps. Each cycle, a reference model predicts the register read-back and the interrupt. This catches reload, prescaler and start/stop ordering errors that only show up under overlapping events.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int PTV_W = 3;
  localparam int PRE_W = 2 ** PTV_W;

  localparam logic [1:0] ADDR_CTRL = 2'd0;
  localparam logic [1:0] ADDR_LOAD = 2'd1;
  localparam logic [1:0] ADDR_CNT  = 2'd2;

  typedef struct packed {
    logic             ie;
    logic             en;
    logic [PTV_W-1:0] ptv;
    logic             ar;
    logic             st;
  } tmr_ctrl_t;

  localparam int CTRL_W = $bits(tmr_ctrl_t);
endpackage

// File: rtl/tmr_regs.sv
module tmr_regs
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [1:0]        addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  input  logic              expire_stop_i,
  output tmr_ctrl_t         ctrl_o,
  output logic [CNT_W-1:0]  load_o,
  output logic              arm_o
);
  tmr_ctrl_t        ctrl_q, wr_ctrl;
  logic [CNT_W-1:0] load_q;
  logic             ctrl_we, load_we;

  assign ctrl_we = we_i && (addr_i == ADDR_CTRL);
  assign load_we = we_i && (addr_i == ADDR_LOAD);
  assign wr_ctrl = tmr_ctrl_t'(wdata_i[CTRL_W-1:0]);
  // start edge from software arms the counter
  assign arm_o   = ctrl_we && wr_ctrl.st && !ctrl_q.st;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
    end else if (ctrl_we) begin
      ctrl_q <= wr_ctrl;
    end else if (expire_stop_i) begin
      ctrl_q.st <= 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      load_q <= '0;
    else if (load_we) load_q <= wdata_i[CNT_W-1:0];
  end

  assign ctrl_o = ctrl_q;
  assign load_o = load_q;
endmodule

// File: rtl/tmr_presc.sv
module tmr_presc
  import tmr_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             run_i,
  input  logic             clear_i,
  input  logic [PTV_W-1:0] ptv_i,
  output logic             tick_o
);
  logic [PRE_W-1:0] pre_q, mask;

  always_comb begin
    for (int i = 0; i < PRE_W; i++) begin
      mask[i] = (PTV_W'(i) <= ptv_i);
    end
  end

  assign tick_o = run_i && ((pre_q & mask) == mask);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      pre_q <= '0;
    else if (clear_i) pre_q <= '0;
    else if (run_i)   pre_q <= tick_o ? '0 : pre_q + 1'b1;
  end
endmodule

// File: rtl/tmr_core.sv
module tmr_core #(
  parameter int CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             arm_i,
  input  logic             tick_i,
  input  logic             ar_i,
  input  logic             ie_i,
  input  logic [CNT_W-1:0] load_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             expire_stop_o,
  output logic             irq_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             irq_q, expire;

  assign expire        = tick_i && (cnt_q <= CNT_W'(1));
  assign expire_stop_o = expire && !ar_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      irq_q <= 1'b0;
    end else begin
      irq_q <= expire && ie_i;
      if (arm_i)       cnt_q <= load_i;
      else if (expire) cnt_q <= ar_i ? load_i : '0;
      else if (tick_i) cnt_q <= cnt_q - CNT_W'(1);
    end
  end

  assign cnt_o = cnt_q;
  assign irq_o = irq_q;
endmodule

// File: rtl/tmr_top.sv
module tmr_top
  import tmr_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              fclk_en_i,
  input  logic              reg_we_i,
  input  logic [1:0]        reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  tmr_ctrl_t        ctrl;
  logic [CNT_W-1:0] load, cnt;
  logic             arm, run, tick, expire_stop;

  assign run = ctrl.st && ctrl.en && fclk_en_i;

  tmr_regs #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_regs (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .we_i          (reg_we_i),
    .addr_i        (reg_addr_i),
    .wdata_i       (reg_wdata_i),
    .expire_stop_i (expire_stop),
    .ctrl_o        (ctrl),
    .load_o        (load),
    .arm_o         (arm)
  );

  tmr_presc u_presc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .run_i   (run),
    .clear_i (arm),
    .ptv_i   (ctrl.ptv),
    .tick_o  (tick)
  );

  tmr_core #(.CNT_W(CNT_W)) u_core (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .arm_i         (arm),
    .tick_i        (tick),
    .ar_i          (ctrl.ar),
    .ie_i          (ctrl.ie),
    .load_i        (load),
    .cnt_o         (cnt),
    .expire_stop_o (expire_stop),
    .irq_o         (irq_o)
  );

  always_comb begin
    unique case (reg_addr_i)
      ADDR_CTRL: reg_rdata_o = DATA_W'(ctrl);
      ADDR_LOAD: reg_rdata_o = DATA_W'(load);
      ADDR_CNT:  reg_rdata_o = DATA_W'(cnt);
      default:   reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/tmr_chk.sv
module tmr_chk #(
  parameter int CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             we_i,
  input logic             run_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [CNT_W-1:0] load_i,
  input logic             st_i,
  input logic             ar_i,
  input logic             ie_i,
  input logic             irq_i
);
  assert_irq_single_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |=> !irq_i);

  assert_irq_gated_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_i |-> $past(ie_i));

  assert_hold_when_idle_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i && !we_i) |=> $stable(cnt_i));

  assert_oneshot_stop_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_i && !$past(we_i) && !$past(ar_i)) |-> (!st_i && (cnt_i == '0)));

  assert_count_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(run_i) && !$past(we_i) && (cnt_i != $past(cnt_i))) |->
      ((cnt_i == $past(cnt_i) - CNT_W'(1)) || (cnt_i == $past(load_i)) || (cnt_i == '0)));
endmodule

bind tmr_top tmr_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_i  (clk_i),
  .rst_ni (rst_ni),
  .we_i   (reg_we_i),
  .run_i  (run),
  .cnt_i  (cnt),
  .load_i (load),
  .st_i   (ctrl.st),
  .ar_i   (ctrl.ar),
  .ie_i   (ctrl.ie),
  .irq_i  (irq_o)
);

// File: tb/tmr_top_tb.sv
module tmr_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fclk = 1'b1;
  logic        we = 1'b0;
  logic [1:0]  addr = 2'd2;
  logic [31:0] wd = '0;
  logic [31:0] rdata;
  logic        irq;

  int n_chk = 0;
  int n_fail = 0;
  bit done = 0;

  // reference model state
  logic       m_ie, m_en, m_ar, m_st;
  logic [2:0] m_ptv;
  logic [31:0] m_load, m_cnt;
  logic [7:0] m_pre;
  logic       m_irq;

  always #10 clk = ~clk;

  tmr_top u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_n),
    .fclk_en_i   (fclk),
    .reg_we_i    (we),
    .reg_addr_i  (addr),
    .reg_wdata_i (wd),
    .reg_rdata_o (rdata),
    .irq_o       (irq)
  );

  function automatic logic [7:0] mask_f(logic [2:0] p);
    logic [7:0] m;
    for (int i = 0; i < 8; i++) m[i] = (i <= int'(p));
    return m;
  endfunction

  function automatic logic [31:0] exp_rd(logic [1:0] a);
    case (a)
      2'd0:    return {25'd0, m_ie, m_en, m_ptv, m_ar, m_st};
      2'd1:    return m_load;
      2'd2:    return m_cnt;
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      {m_ie, m_en, m_ptv, m_ar, m_st} = '0;
      m_load = '0; m_cnt = '0; m_pre = '0; m_irq = 1'b0;
    end else begin
      logic run, tick, expd, arm;
      logic [7:0] msk;
      run  = m_st && m_en && fclk;
      msk  = mask_f(m_ptv);
      tick = run && ((m_pre & msk) == msk);
      expd = tick && (m_cnt <= 32'd1);
      arm  = we && (addr == 2'd0) && wd[0] && !m_st;
      m_irq = expd && m_ie;
      if (arm)       m_cnt = m_load;
      else if (expd) m_cnt = m_ar ? m_load : 32'd0;
      else if (tick) m_cnt = m_cnt - 32'd1;
      if (arm)      m_pre = '0;
      else if (run) m_pre = tick ? 8'd0 : m_pre + 8'd1;
      if (we && addr == 2'd0)     {m_ie, m_en, m_ptv, m_ar, m_st} = wd[6:0];
      else if (expd && !m_ar)     m_st = 1'b0;
      if (we && addr == 2'd1)     m_load = wd;
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one cycle at the falling edge, then compare against the model
  task automatic step(logic w, logic [1:0] a, logic [31:0] d, logic f);
    @(negedge clk);
    we = w; addr = a; wd = d; fclk = f;
    #1;
    chk(a == 2'd2 ? "R4 count" : "R2 readback", rdata, exp_rd(a));
    chk("R8 irq", {31'd0, irq}, {31'd0, m_irq});
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) step(1'b0, 2'd2, 32'd0, 1'b1);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    #3;
    addr = 2'd0; #1; chk("R1 ctrl", rdata, 32'd0);
    addr = 2'd2; #1; chk("R1 count", rdata, 32'd0);
    chk("R1 irq", {31'd0, irq}, 32'd0);
    repeat (2) @(negedge clk);
    rst_n = 1'b1;

    // one-shot, p=0, interrupt on
    step(1'b1, 2'd1, 32'd3, 1'b1);
    step(1'b1, 2'd0, 32'h61, 1'b1);
    step(1'b0, 2'd2, 0, 1'b1);
    chk("R3 armed count", rdata, 32'd3);
    idle(2); chk("R4 first step", rdata, 32'd2);
    idle(2); chk("R4 second step", rdata, 32'd1);
    idle(2); chk("R6 parked at zero", rdata, 32'd0);
    chk("R8 pulse on expiry", {31'd0, irq}, 32'd1);
    step(1'b0, 2'd0, 0, 1'b1);
    chk("R6 start cleared", rdata, 32'h60);
    chk("R8 pulse single cycle", {31'd0, irq}, 32'd0);

    // auto-reload, interrupt off
    step(1'b1, 2'd1, 32'd2, 1'b1);
    step(1'b1, 2'd0, 32'h23, 1'b1);
    idle(1); chk("R3 armed count", rdata, 32'd2);
    idle(2); chk("R4 step", rdata, 32'd1);
    idle(2); chk("R7 reloaded", rdata, 32'd2);
    chk("R8 no pulse when disabled", {31'd0, irq}, 32'd0);

    // functional clock gated
    for (int i = 0; i < 6; i++) step(1'b0, 2'd2, 0, 1'b0);
    chk("R5 hold while gated", rdata, 32'd2);
    step(1'b1, 2'd0, 32'h0, 1'b1);

    // write colliding with one-shot expiry
    step(1'b1, 2'd1, 32'd1, 1'b1);
    step(1'b1, 2'd0, 32'h21, 1'b1);
    step(1'b0, 2'd2, 0, 1'b1);
    step(1'b1, 2'd0, 32'h21, 1'b1);
    step(1'b0, 2'd0, 0, 1'b1);
    chk("R9 write wins over stop", rdata, 32'h21);
    step(1'b0, 2'd2, 0, 1'b1);
    chk("R9 count parked", rdata, 32'd0);
    step(1'b1, 2'd0, 32'h0, 1'b1);

    // random mix against the model
    for (int i = 0; i < 20000; i++) begin
      logic        w;
      logic [1:0]  a;
      logic [31:0] d;
      logic        f;
      w = ($urandom_range(15) == 0);
      a = 2'($urandom_range(3));
      f = ($urandom_range(7) != 0);
      if (a == 2'd0) begin
        d = {25'd0, 1'($urandom_range(1)), ($urandom_range(3) != 0),
             ($urandom_range(7) == 0) ? 3'($urandom_range(7)) : 3'($urandom_range(2)),
             1'($urandom_range(1)), ($urandom_range(2) != 0)};
      end else begin
        d = 32'($urandom_range(12));
      end
      step(w, a, d, f);
    end

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule